// File: doc/BRIEF.md
# Fragment Reassembling Receiver

This engine pulls a message out of an inbound circular buffer of 32-bit slots, where the message may be split across several fragments. Every fragment begins with a header slot that carries a byte length and a flag marking the last fragment. The payload slots follow the header. The engine presents the payload bytes one per cycle on a byte stream. It keeps reading fragments until one carries the last-fragment flag, or until the next fragment would not fit in the space the caller allowed.

A receive starts with a one-cycle `start` pulse. With that pulse the caller supplies a byte capacity and a wait limit in cycles. While it runs, the engine watches the buffer's filled-slot count and pops slots only when enough of them are present. If it finishes a fragment that is not the last one and the buffer is empty, it raises a one-cycle doorbell so that the sender pushes more data. At the end it pulses `done` and holds four results until the next start: the number of bytes delivered, a success flag, a zero-length warning and a timeout flag.

Top module: `frag_reassembly_rx`

## Requirements
- R1: A header slot is decoded with the fragment byte length in bits 24:16 and the last-fragment flag in bit 31. All other header bits are ignored.
- R2: The engine pops a header only when the filled count is at least one. It pops a fragment's payload only after ceil(len/4) slots are filled. Each fragment consumes exactly 1 + ceil(len/4) slots, and no slot is read after the last fragment.
- R3: A fragment whose length exceeds the capacity still unused ends the receive as a failure. None of that fragment's payload is popped or emitted. Bytes delivered up to that point are still counted.
- R4: Payload bytes leave lowest byte first within each slot. For the final slot of a fragment, only len mod 4 bytes (1 to 3) are emitted when that value is nonzero.
- R5: When a fragment without the last-fragment flag ends and the filled count is zero, `doorbell` pulses high for one cycle. It stays low if slots are already waiting.
- R6: `ok` is 1 only if the last fragment read had the flag set, had a nonzero length, and `far_ready` was high when the receive ended.
- R7: `total_len` equals the number of bytes emitted on the byte stream during the receive.
- R8: Fragments are appended in arrival order until a fragment with the last-fragment flag is read.
- R9: A fragment of length zero sets `warn_zero`, emits no bytes and ends the receive.
- R10: If a wait for the header or for the payload slots lasts `timeout_limit` cycles, the receive ends with `timeout_err` = 1 and `ok` = 0.
- R11: `done` is a single-cycle pulse. `busy` is high from the cycle after `start` until `done`. While idle the engine pops nothing, emits nothing and rings no doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a receive (taken when idle) |
| capacity | input | CAP_W | Maximum bytes the caller accepts |
| timeout_limit | input | TO_W | Cycles allowed for any single wait |
| far_ready | input | 1 | Sender-side ready indication |
| fill_count | input | CNT_W | Filled slots in the inbound buffer |
| slot_data | input | 32 | Oldest filled slot |
| slot_pop | output | 1 | Consume the oldest slot this cycle |
| out_valid | output | 1 | A payload byte is present |
| out_byte | output | 8 | Payload byte |
| doorbell | output | 1 | Request the sender to push more |
| busy | output | 1 | Receive in progress |
| done | output | 1 | Receive finished (one cycle) |
| ok | output | 1 | Receive succeeded |
| total_len | output | CAP_W | Bytes delivered |
| warn_zero | output | 1 | A zero-length fragment was read |
| timeout_err | output | 1 | A wait expired |

## Verification
The case that is hardest to reach from the ports is the doorbell in the middle of a message. The buffer has to run empty exactly when a non-final fragment ends, and the receive must still be live so that a later fragment can complete it. The stimulus pushes only the first fragment and starts the receive. It then polls the doorbell and checks that `done` has not fired. Only after that does it push the closing fragment. A companion run queues both fragments in advance and expects no doorbell. Capacity aborts are checked by how many slots remain in the buffer, which shows that no payload was popped.

// File: rtl/frx_pkg.sv
package frx_pkg;

    localparam int SLOT_W      = 32;
    localparam int LEN_W       = 9;
    localparam int HDR_LEN_LSB = 16;
    localparam int HDR_END_BIT = 31;

    typedef struct packed {
        logic             last;
        logic [LEN_W-1:0] len;
    } frx_hdr_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_BODYW,
        S_LOAD,
        S_EMIT,
        S_NEXT,
        S_DONE
    } frx_state_t;

    function automatic frx_hdr_t frx_decode(input logic [SLOT_W-1:0] w);
        frx_hdr_t h;
        h.last = w[HDR_END_BIT];
        h.len  = w[HDR_LEN_LSB +: LEN_W];
        return h;
    endfunction

    function automatic logic [LEN_W-1:0] frx_slots(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] t;
        t = {1'b0, len} + (LEN_W+1)'(3);
        return t[LEN_W:0] >> 2;
    endfunction

endpackage

// File: rtl/frx_wait_timer.sv
module frx_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] count;
    logic         reached;

    assign reached = (count >= limit);
    assign expired = en && reached;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            count <= '0;
        end else if (!reached) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/frx_unpacker.sv
module frx_unpacker #(
    parameter int SLOT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOT_W-1:0] word_in,
    input  logic              advance,
    output logic [7:0]        byte_out,
    output logic              at_last
);
    localparam int NB    = SLOT_W / 8;
    localparam int IDX_W = $clog2(NB);

    logic [SLOT_W-1:0] word_q;
    logic [IDX_W-1:0]  idx;

    assign byte_out = word_q[idx*8 +: 8];
    assign at_last  = (idx == IDX_W'(NB-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx    <= '0;
        end else if (load) begin
            word_q <= word_in;
            idx    <= '0;
        end else if (advance) begin
            idx <= idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/frag_reassembly_rx.sv
module frag_reassembly_rx
    import frx_pkg::*;
#(
    parameter int CAP_W = 16,
    parameter int CNT_W = 8,
    parameter int TO_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CAP_W-1:0]  capacity,
    input  logic [TO_W-1:0]   timeout_limit,
    input  logic              far_ready,
    input  logic [CNT_W-1:0]  fill_count,
    input  logic [31:0]       slot_data,
    output logic              slot_pop,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              doorbell,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic [CAP_W-1:0]  total_len,
    output logic              warn_zero,
    output logic              timeout_err
);
    localparam int WIDE_W = (CAP_W > CNT_W ? CAP_W : CNT_W) + LEN_W;

    frx_state_t        state;
    frx_hdr_t          hdr_q;
    frx_hdr_t          hdr_in;
    logic [CAP_W-1:0]  left_q;
    logic [LEN_W-1:0]  rem_q;
    logic [TO_W-1:0]   limit_q;
    logic              waiting;
    logic              expired;
    logic              have_hdr;
    logic              have_body;
    logic              too_long;
    logic              at_last;

    assign hdr_in    = frx_decode(slot_data);
    assign have_hdr  = (fill_count != '0);
    assign have_body = WIDE_W'(fill_count) >= WIDE_W'(frx_slots(hdr_q.len));
    assign too_long  = WIDE_W'(hdr_in.len) > WIDE_W'(left_q);
    assign waiting   = (state == S_HDR && !have_hdr) ||
                       (state == S_BODYW && !have_body);

    assign slot_pop  = (state == S_HDR && have_hdr) || (state == S_LOAD);
    assign out_valid = (state == S_EMIT);
    assign doorbell  = (state == S_NEXT) && !hdr_q.last && (fill_count == '0);
    assign busy      = (state != S_IDLE);
    assign done      = (state == S_DONE);

    frx_wait_timer #(.W(TO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (waiting),
        .limit   (limit_q),
        .expired (expired)
    );

    frx_unpacker #(.SLOT_W(SLOT_W)) u_unpack (
        .clk      (clk),
        .rst      (rst),
        .load     (state == S_LOAD),
        .word_in  (slot_data),
        .advance  (state == S_EMIT),
        .byte_out (out_byte),
        .at_last  (at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            hdr_q       <= '0;
            left_q      <= '0;
            rem_q       <= '0;
            limit_q     <= '0;
            total_len   <= '0;
            ok          <= 1'b0;
            warn_zero   <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        left_q      <= capacity;
                        limit_q     <= timeout_limit;
                        total_len   <= '0;
                        ok          <= 1'b0;
                        warn_zero   <= 1'b0;
                        timeout_err <= 1'b0;
                        hdr_q       <= '0;
                        state       <= S_HDR;
                    end
                end
                S_HDR: begin
                    if (have_hdr) begin
                        hdr_q <= hdr_in;
                        rem_q <= hdr_in.len;
                        if (hdr_in.len == '0) begin
                            warn_zero <= 1'b1;
                            state     <= S_NEXT;
                        end else if (too_long) begin
                            state <= S_DONE;
                        end else begin
                            state <= S_BODYW;
                        end
                    end else if (expired) begin
                        timeout_err <= 1'b1;
                        state       <= S_DONE;
                    end
                end
                S_BODYW: begin
                    if (have_body) begin
                        state <= S_LOAD;
                    end else if (expired) begin
                        timeout_err <= 1'b1;
                        state       <= S_DONE;
                    end
                end
                S_LOAD: begin
                    state <= S_EMIT;
                end
                S_EMIT: begin
                    total_len <= total_len + CAP_W'(1);
                    left_q    <= left_q - CAP_W'(1);
                    rem_q     <= rem_q - LEN_W'(1);
                    if (rem_q == LEN_W'(1)) begin
                        state <= S_NEXT;
                    end else if (at_last) begin
                        state <= S_LOAD;
                    end
                end
                S_NEXT: begin
                    if (hdr_q.len != '0 && !hdr_q.last && left_q != '0) begin
                        state <= S_HDR;
                    end else begin
                        ok    <= hdr_q.last && (hdr_q.len != '0) && far_ready;
                        state <= S_DONE;
                    end
                end
                S_DONE: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frx_checker.sv
module frx_checker #(
    parameter int CAP_W = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CAP_W-1:0] capacity,
    input logic             far_ready,
    input logic [CNT_W-1:0] fill_count,
    input logic             slot_pop,
    input logic             out_valid,
    input logic             doorbell,
    input logic             busy,
    input logic             done,
    input logic             ok,
    input logic [CAP_W-1:0] total_len,
    input logic             timeout_err
);
    logic [CAP_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else if (start && !busy) cap_q <= capacity;
    end

    // R2: never pop from an empty buffer
    p_pop_needs_fill_r2: assert property (@(posedge clk) disable iff (rst)
        slot_pop |-> fill_count != '0);

    // R3: delivered bytes never exceed the capacity given at start
    p_within_cap_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> total_len <= cap_q);

    // R4: bytes are emitted only while busy and never in a pop cycle
    p_emit_busy_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy && !slot_pop);

    // R5: doorbell only with a drained buffer, one cycle wide
    p_doorbell_drained_r5: assert property (@(posedge clk) disable iff (rst)
        doorbell |-> fill_count == '0 && !out_valid);
    p_doorbell_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        doorbell |=> !doorbell);

    // R6: success implies ready sender, data delivered and no timeout
    p_ok_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (done && ok) |-> far_ready && total_len != '0 && !timeout_err);

    // R11: done is a pulse, and idle is quiet
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !slot_pop && !out_valid && !doorbell);
endmodule

bind frag_reassembly_rx frx_checker #(.CAP_W(CAP_W), .CNT_W(CNT_W)) u_frx_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .capacity    (capacity),
    .far_ready   (far_ready),
    .fill_count  (fill_count),
    .slot_pop    (slot_pop),
    .out_valid   (out_valid),
    .doorbell    (doorbell),
    .busy        (busy),
    .done        (done),
    .ok          (ok),
    .total_len   (total_len),
    .timeout_err (timeout_err)
);

// File: tb/frag_reassembly_rx_bench.sv
`timescale 1ns/1ps
module frag_reassembly_rx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] capacity = '0;
    logic [15:0] timeout_limit = '0;
    logic        far_ready = 1'b1;
    logic [7:0]  fill_count;
    logic [31:0] slot_data;
    logic        slot_pop, out_valid, doorbell, busy, done, ok, warn_zero, timeout_err;
    logic [7:0]  out_byte;
    logic [15:0] total_len;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:63];
    int wp = 0;
    int rp = 0;
    logic flush = 1'b0;

    int got [0:255];
    int ngot = 0;
    int exp_b [0:255];
    int nexp = 0;
    int dbells = 0;

    always #2.5 clk = ~clk;

    assign fill_count = 8'(wp - rp);
    assign slot_data  = mem[rp % 64];

    always @(posedge clk) begin
        if (flush) rp <= wp;
        else if (slot_pop) rp <= rp + 1;
    end

    always @(negedge clk) begin
        if (out_valid) begin got[ngot] = int'(out_byte); ngot = ngot + 1; end
        if (doorbell) dbells = dbells + 1;
    end

    frag_reassembly_rx u_frag_reassembly_rx (
        .clk(clk), .rst(rst), .start(start), .capacity(capacity),
        .timeout_limit(timeout_limit), .far_ready(far_ready),
        .fill_count(fill_count), .slot_data(slot_data), .slot_pop(slot_pop),
        .out_valid(out_valid), .out_byte(out_byte), .doorbell(doorbell),
        .busy(busy), .done(done), .ok(ok), .total_len(total_len),
        .warn_zero(warn_zero), .timeout_err(timeout_err)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks = checks + 1;
        if (act != expv) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        mem[wp % 64] = w;
        wp = wp + 1;
    endtask

    // R1: length in 24:16, last flag in 31; noise in 30:25 and 15:0
    task automatic push_frag(input int len, input bit last, input int seed, input bit expect_bytes);
        logic [31:0] w;
        push({last, 6'h2A, 9'(len), 16'h0307});
        for (int i = 0; i < (len + 3) / 4; i++) begin
            w = 32'(seed * 32'h01010101) + 32'(i * 32'h10203040) + 32'h04030201;
            push(w);
            for (int b = 0; b < 4; b++) begin
                if (expect_bytes && (i * 4 + b) < len) begin
                    exp_b[nexp] = int'(w[b*8 +: 8]);
                    nexp = nexp + 1;
                end
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic clear_stream();
        ngot = 0; nexp = 0; dbells = 0;
    endtask

    task automatic begin_rx(input int cap, input int tmo);
        @(negedge clk);
        capacity = 16'(cap); timeout_limit = 16'(tmo); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk({req, " done reached"}, int'(done), 1);
        @(negedge clk);
        chk("R11 done is one cycle", int'(done), 0);
    endtask

    task automatic chk_stream(input string req);
        int bad;
        bad = 0;
        chk({req, " byte count"}, ngot, nexp);
        for (int i = 0; i < nexp && i < ngot; i++) if (got[i] != exp_b[i]) bad++;
        chk({req, " byte mismatches"}, bad, 0);
    endtask

    task automatic t_single();
        clear_stream();
        push_frag(6, 1'b1, 3, 1'b1);
        push(32'hDEADBEEF);
        begin_rx(64, 1000);
        chk("R11 busy after start", int'(busy), 1);
        wait_done("R4");
        chk("R6 ok single", int'(ok), 1);
        chk("R7 total single", int'(total_len), 6);
        chk_stream("R4");
        chk("R2 extra slot untouched", int'(fill_count), 1);
        chk("R5 no doorbell", dbells, 0);
        do_flush();
    endtask

    task automatic t_multi_queued();
        clear_stream();
        push_frag(8, 1'b0, 5, 1'b1);
        push_frag(5, 1'b1, 9, 1'b1);
        begin_rx(64, 1000);
        wait_done("R8");
        chk("R8 ok reassembled", int'(ok), 1);
        chk("R7 total reassembled", int'(total_len), 13);
        chk_stream("R8");
        chk("R5 no doorbell when queued", dbells, 0);
        chk("R2 all slots consumed", int'(fill_count), 0);
    endtask

    task automatic t_drain_doorbell();
        int n;
        clear_stream();
        push_frag(4, 1'b0, 11, 1'b1);
        begin_rx(64, 1000);
        n = 0;
        while (dbells == 0 && n < 500) begin @(negedge clk); n++; end
        chk("R5 doorbell after drain", dbells, 1);
        chk("R5 still busy", int'(busy), 1);
        push_frag(3, 1'b1, 13, 1'b1);
        wait_done("R5");
        chk("R5 ok after refill", int'(ok), 1);
        chk("R7 total after refill", int'(total_len), 7);
        chk("R5 single doorbell", dbells, 1);
        chk_stream("R5");
    endtask

    task automatic t_capacity();
        clear_stream();
        push_frag(8, 1'b1, 2, 1'b0);
        begin_rx(5, 1000);
        wait_done("R3");
        chk("R3 ok on overflow", int'(ok), 0);
        chk("R3 total on overflow", int'(total_len), 0);
        chk("R3 no bytes", ngot, 0);
        chk("R3 payload left in buffer", int'(fill_count), 2);
        do_flush();
        clear_stream();
        push_frag(4, 1'b0, 6, 1'b1);
        push_frag(4, 1'b1, 7, 1'b0);
        begin_rx(6, 1000);
        wait_done("R3");
        chk("R3 ok second overflows", int'(ok), 0);
        chk("R7 total before overflow", int'(total_len), 4);
        chk_stream("R3");
        do_flush();
        clear_stream();
        push_frag(4, 1'b1, 8, 1'b1);
        begin_rx(4, 1000);
        wait_done("R3");
        chk("R3 exact fit ok", int'(ok), 1);
        chk("R3 exact fit total", int'(total_len), 4);
    endtask

    task automatic t_zero_len();
        clear_stream();
        push_frag(0, 1'b1, 0, 1'b0);
        begin_rx(64, 1000);
        wait_done("R9");
        chk("R9 warn set", int'(warn_zero), 1);
        chk("R9 ok clear", int'(ok), 0);
        chk("R9 no bytes", ngot, 0);
        chk("R9 total zero", int'(total_len), 0);
    endtask

    task automatic t_timeouts();
        clear_stream();
        begin_rx(64, 20);
        wait_done("R10");
        chk("R10 header timeout flag", int'(timeout_err), 1);
        chk("R10 header timeout ok", int'(ok), 0);
        chk("R9 warn cleared by start", int'(warn_zero), 0);
        clear_stream();
        push({1'b1, 6'h0, 9'd8, 16'h0});
        begin_rx(64, 20);
        wait_done("R10");
        chk("R10 body timeout flag", int'(timeout_err), 1);
        chk("R10 body timeout total", int'(total_len), 0);
        chk("R10 body timeout bytes", ngot, 0);
        do_flush();
    endtask

    task automatic t_far_not_ready();
        clear_stream();
        far_ready = 1'b0;
        push_frag(4, 1'b1, 21, 1'b1);
        begin_rx(64, 1000);
        wait_done("R6");
        chk("R6 ok needs far ready", int'(ok), 0);
        chk("R7 total without ready", int'(total_len), 4);
        chk_stream("R6");
        far_ready = 1'b1;
    endtask

    initial begin
        #1000000;
        errors = errors + 1;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset done", int'(done), 0);
        chk("R11 reset out_valid", int'(out_valid), 0);
        chk("R11 reset pop", int'(slot_pop), 0);
        t_single();
        t_multi_queued();
        t_drain_doorbell();
        t_capacity();
        t_zero_len();
        t_timeouts();
        t_far_not_ready();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule